// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped by looking at its 48-bit destination address and its length. Frames are presented with a single-cycle strobe. One clock later the block gives a registered verdict, together with a flag that marks the frame as sent to a group address (broadcast or multicast).

Multicast destinations are filtered through a 64-bin hash table. Software loads the table from a list of group addresses. It starts a load by giving the list length in bytes. The table is then wiped and the block accepts the addresses one at a time through a ready/valid pair. Each address is hashed a byte per clock by a CRC-32 unit. Six bits of the result pick the bin to set. A one-cycle done pulse marks the end of the list.

The verdict depends on three configuration flags (promiscuous, broadcast disable, multicast enable), a minimum frame length and the station's own individual address.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted and after it is released, dec_valid, dec_accept, dec_group, mc_ready and list_done are 0. The hash table starts with every bin empty, so a multicast frame is rejected before any list is loaded.
- R2: dec_valid is high exactly in the cycle after a cycle with frm_valid high. dec_accept and dec_group give the verdict for that frame.
- R3: A frame whose frm_len is below the larger of cfg_min_len and 5 is rejected with dec_group 0, whatever the other flags and the destination.
- R4: With cfg_promisc set, every frame that passes the length check is accepted with dec_group 0.
- R5: Without promiscuous mode, an all-ones destination is rejected if cfg_bcast_off is set. Otherwise it is accepted with dec_group 1.
- R6: Without promiscuous mode, a destination that is not all ones and has bit 0 of its first byte set (frm_dst[40]; the first byte on the wire is frm_dst[47:40]) is multicast. It is accepted with dec_group 1 only if cfg_mcast_en is set and its hash bin is set. Otherwise it is rejected.
- R7: Any other destination is accepted with dec_group 0 only if it equals station_addr. Otherwise it is rejected.
- R8: A list_start pulse clears all 64 bins. The number of addresses then taken is list_len divided by 6, rounded down and capped at 64. Once that many have been taken, mc_ready stays low.
- R9: The bin of an address is bits 7..2 of a reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, no final inversion). The CRC runs over the six address bytes from frm_dst[47:40] down to [7:0], with each byte taken least significant bit first. The same bin index is used for loading and for lookup.
- R10: An address is taken in a cycle with mc_valid and mc_ready both high. mc_ready is then low for exactly 6 clocks while that address is hashed.
- R11: list_done pulses for one clock, one clock after the last address of the list has been hashed, or one clock after the start cycle when the count is 0. mc_valid while mc_ready is low has no effect on the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_promisc | input | 1 | Accept every frame of legal length |
| cfg_bcast_off | input | 1 | Reject all-ones destinations |
| cfg_mcast_en | input | 1 | Allow multicast frames whose bin is set |
| cfg_min_len | input | 8 | Minimum frame length in bytes (5 is used if smaller) |
| station_addr | input | 48 | Individual address of this station |
| list_start | input | 1 | Start loading a new multicast list; clears the table |
| list_len | input | 16 | Length of the list in bytes |
| mc_valid | input | 1 | mc_addr holds the next list address |
| mc_addr | input | 48 | Multicast address to add to the table |
| mc_ready | output | 1 | Block can take an address |
| list_done | output | 1 | One-cycle pulse at end of the list |
| frm_valid | input | 1 | Frame strobe; frm_dst and frm_len are valid |
| frm_dst | input | 48 | Destination address of the frame |
| frm_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame accepted |
| dec_group | output | 1 | Accepted frame was broadcast or multicast |

## Verification
The assertions assume three things about the inputs. The configuration flags, station_addr and the frame inputs are stable around each rising edge. list_start is not raised in the same cycle as a frame whose verdict depends on the table. Addresses are offered only on mc_valid, with mc_ready taken as the acceptance condition. The stimulus changes every input only at the falling edge, changes configuration only between frames, and waits for mc_ready before each address. The stimulus also deliberately raises mc_valid while mc_ready is low, which R11 must tolerate.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_WAIT,
    LD_HASH
  } ld_state_e;

  // one byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_crc_chain.sv
module rxf_crc_chain #(
  parameter int NBYTES = 6,
  parameter int IDX_W  = 6
) (
  input  logic [8*NBYTES-1:0] data,
  output logic [IDX_W-1:0]    idx
);
  import rxf_pkg::*;

  logic [31:0] stage [NBYTES+1];

  assign stage[0] = '1;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign stage[g+1] = crc_byte(stage[g], data[8*NBYTES-1-8*g -: 8]);
  end

  assign idx = stage[NBYTES][IDX_W+1:2];

endmodule

// File: rtl/rxf_hash_loader.sv
module rxf_hash_loader #(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 16,
  parameter int HASH_BITS = 6,
  parameter int MAX_MC    = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      list_start,
  input  logic [LEN_W-1:0]          list_len,
  input  logic                      mc_valid,
  input  logic [ADDR_W-1:0]         mc_addr,
  output logic                      mc_ready,
  output logic                      list_done,
  output logic [(1<<HASH_BITS)-1:0] table_o
);
  import rxf_pkg::*;

  localparam int NBYTES = ADDR_W / 8;
  localparam int TBL_W  = 1 << HASH_BITS;
  localparam int CNT_W  = $clog2(MAX_MC + 1);
  localparam int K_W    = $clog2(NBYTES);

  ld_state_e          st_q, st_n;
  logic [CNT_W-1:0]   rem_q, rem_n;
  logic [K_W-1:0]     k_q, k_n;
  logic [31:0]        crc_q, crc_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic [TBL_W-1:0]   tbl_q, tbl_n;
  logic               done_q, done_n;
  logic [LEN_W-1:0]   quot;
  logic [CNT_W-1:0]   cnt_cap;
  logic [31:0]        step;

  assign quot    = list_len / LEN_W'(NBYTES);
  assign cnt_cap = (quot > LEN_W'(MAX_MC)) ? CNT_W'(MAX_MC) : quot[CNT_W-1:0];
  assign step    = crc_byte(crc_q, addr_q[ADDR_W-1-8*k_q -: 8]);

  always_comb begin
    st_n   = st_q;
    rem_n  = rem_q;
    k_n    = k_q;
    crc_n  = crc_q;
    addr_n = addr_q;
    tbl_n  = tbl_q;
    done_n = 1'b0;
    case (st_q)
      LD_WAIT: begin
        if (rem_q == '0) begin
          done_n = 1'b1;
          st_n   = LD_IDLE;
        end else if (mc_valid) begin
          addr_n = mc_addr;
          crc_n  = '1;
          k_n    = '0;
          st_n   = LD_HASH;
        end
      end
      LD_HASH: begin
        crc_n = step;
        k_n   = k_q + 1'b1;
        if (k_q == K_W'(NBYTES - 1)) begin
          tbl_n[step[HASH_BITS+1:2]] = 1'b1;
          rem_n = rem_q - 1'b1;
          st_n  = LD_WAIT;
        end
      end
      default: ;
    endcase
    if (list_start) begin
      tbl_n = '0;
      rem_n = cnt_cap;
      st_n  = LD_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LD_IDLE;
      rem_q  <= '0;
      k_q    <= '0;
      crc_q  <= '0;
      addr_q <= '0;
      tbl_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      rem_q  <= rem_n;
      k_q    <= k_n;
      crc_q  <= crc_n;
      addr_q <= addr_n;
      tbl_q  <= tbl_n;
      done_q <= done_n;
    end
  end

  assign mc_ready  = (st_q == LD_WAIT) && (rem_q != '0);
  assign list_done = done_q;
  assign table_o   = tbl_q;

  // R10
  hash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && mc_ready && !list_start) |=> !mc_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    list_done |=> !list_done);

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 16,
  parameter int HASH_BITS = 6,
  parameter int MIN_FLOOR = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_promisc,
  input  logic                      cfg_bcast_off,
  input  logic                      cfg_mcast_en,
  input  logic [7:0]                cfg_min_len,
  input  logic [ADDR_W-1:0]         station_addr,
  input  logic [(1<<HASH_BITS)-1:0] table_i,
  input  logic                      frm_valid,
  input  logic [ADDR_W-1:0]         frm_dst,
  input  logic [LEN_W-1:0]          frm_len,
  output logic                      dec_valid,
  output logic                      dec_accept,
  output logic                      dec_group
);
  localparam int NBYTES = ADDR_W / 8;

  logic [HASH_BITS-1:0] idx;
  logic [7:0]           min_eff;
  logic                 too_short, is_bc, is_mc, acc, grp;
  logic                 vld_q, acc_q, grp_q;

  rxf_crc_chain #(.NBYTES(NBYTES), .IDX_W(HASH_BITS)) u_chain (
    .data (frm_dst),
    .idx  (idx)
  );

  assign min_eff   = (cfg_min_len < 8'(MIN_FLOOR)) ? 8'(MIN_FLOOR) : cfg_min_len;
  assign too_short = frm_len < LEN_W'(min_eff);
  assign is_bc     = &frm_dst;
  assign is_mc     = frm_dst[ADDR_W-8];

  always_comb begin
    acc = 1'b0;
    grp = 1'b0;
    if (too_short) begin
      acc = 1'b0;
    end else if (cfg_promisc) begin
      acc = 1'b1;
    end else if (is_bc) begin
      acc = !cfg_bcast_off;
      grp = !cfg_bcast_off;
    end else if (is_mc) begin
      acc = cfg_mcast_en && table_i[idx];
      grp = cfg_mcast_en && table_i[idx];
    end else begin
      acc = (frm_dst == station_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      grp_q <= 1'b0;
    end else begin
      vld_q <= frm_valid;
      if (frm_valid) begin
        acc_q <= acc;
        grp_q <= grp;
      end
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;
  assign dec_group  = grp_q;

  // R3
  short_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_len < LEN_W'(MIN_FLOOR)) |=> (dec_valid && !dec_accept && !dec_group));

  // R4
  promisc_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && cfg_promisc && frm_len >= LEN_W'(MIN_FLOOR) && frm_len >= LEN_W'(cfg_min_len))
    |=> (dec_accept && !dec_group));

  // R5
  bcast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !cfg_promisc && cfg_bcast_off && (&frm_dst)) |=> !dec_accept);

  // R7
  ucast_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !cfg_promisc && !frm_dst[ADDR_W-8] && frm_dst != station_addr) |=> !dec_accept);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 16,
  parameter int HASH_BITS = 6,
  parameter int MAX_MC    = 64,
  parameter int MIN_FLOOR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_promisc,
  input  logic              cfg_bcast_off,
  input  logic              cfg_mcast_en,
  input  logic [7:0]        cfg_min_len,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              list_start,
  input  logic [LEN_W-1:0]  list_len,
  input  logic              mc_valid,
  input  logic [ADDR_W-1:0] mc_addr,
  output logic              mc_ready,
  output logic              list_done,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_dst,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_group
);
  localparam int TBL_W = 1 << HASH_BITS;

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic [TBL_W-1:0] tbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  rxf_hash_loader #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HASH_BITS(HASH_BITS), .MAX_MC(MAX_MC)
  ) u_load (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .list_start (list_start),
    .list_len   (list_len),
    .mc_valid   (mc_valid),
    .mc_addr    (mc_addr),
    .mc_ready   (mc_ready),
    .list_done  (list_done),
    .table_o    (tbl)
  );

  rxf_decide #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .HASH_BITS(HASH_BITS), .MIN_FLOOR(MIN_FLOOR)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .cfg_promisc   (cfg_promisc),
    .cfg_bcast_off (cfg_bcast_off),
    .cfg_mcast_en  (cfg_mcast_en),
    .cfg_min_len   (cfg_min_len),
    .station_addr  (station_addr),
    .table_i       (tbl),
    .frm_valid     (frm_valid),
    .frm_dst       (frm_dst),
    .frm_len       (frm_len),
    .dec_valid     (dec_valid),
    .dec_accept    (dec_accept),
    .dec_group     (dec_group)
  );

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_promisc, cfg_bcast_off, cfg_mcast_en;
  logic [7:0]  cfg_min_len;
  logic [47:0] station_addr;
  logic        list_start;
  logic [15:0] list_len;
  logic        mc_valid;
  logic [47:0] mc_addr;
  logic        mc_ready, list_done;
  logic        frm_valid;
  logic [47:0] frm_dst;
  logic [15:0] frm_len;
  logic        dec_valid, dec_accept, dec_group;

  always #5 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_promisc(cfg_promisc), .cfg_bcast_off(cfg_bcast_off),
    .cfg_mcast_en(cfg_mcast_en), .cfg_min_len(cfg_min_len),
    .station_addr(station_addr),
    .list_start(list_start), .list_len(list_len),
    .mc_valid(mc_valid), .mc_addr(mc_addr),
    .mc_ready(mc_ready), .list_done(list_done),
    .frm_valid(frm_valid), .frm_dst(frm_dst), .frm_len(frm_len),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_group(dec_group)
  );

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [63:0] m_tbl;
  logic        exp_v, exp_acc, exp_grp;
  string       exp_req;

  localparam logic [47:0] STEP = 48'h000000010307;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_bin(input logic [47:0] a);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    return int'(c[7:2]);
  endfunction

  task automatic m_decide(input logic [47:0] d, input int len, output logic acc, output logic grp);
    int mn;
    mn  = (cfg_min_len < 5) ? 5 : int'(cfg_min_len);
    acc = 1'b0;
    grp = 1'b0;
    if (len < mn) return;
    if (cfg_promisc) acc = 1'b1;
    else if (d == 48'hFFFFFFFFFFFF) begin
      if (!cfg_bcast_off) begin acc = 1'b1; grp = 1'b1; end
    end else if (d[40]) begin
      if (cfg_mcast_en && m_tbl[m_bin(d)]) begin acc = 1'b1; grp = 1'b1; end
    end else acc = (d == station_addr);
  endtask

  // per-clock comparison against the reference verdict (R2)
  always begin
    @(posedge clk);
    #2;
    if (exp_v) begin
      chk({exp_req, " R2"}, "dec_valid", int'(dec_valid), 1);
      chk(exp_req, "dec_accept", int'(dec_accept), int'(exp_acc));
      chk(exp_req, "dec_group", int'(dec_group), int'(exp_grp));
    end else if (dec_valid) begin
      chk("R2", "dec_valid without strobe", 1, 0);
    end
  end

  task automatic frame(input logic [47:0] d, input int len, input string req);
    logic a, g;
    @(negedge clk);
    frm_valid = 1'b1;
    frm_dst   = d;
    frm_len   = 16'(len);
    m_decide(d, len, a, g);
    exp_acc = a;
    exp_grp = g;
    exp_req = req;
    exp_v   = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    exp_v     = 1'b0;
  endtask

  task automatic load_list(input int len, input logic [47:0] base);
    int n, c, w;
    n = len / 6;
    if (n > 64) n = 64;
    @(negedge clk);
    list_start = 1'b1;
    list_len   = 16'(len);
    m_tbl      = '0;
    @(negedge clk);
    list_start = 1'b0;
    if (n == 0) begin
      chk("R11", "done before count-0 pulse", int'(list_done), 0);
      @(negedge clk);
      chk("R11", "done for empty list", int'(list_done), 1);
      @(negedge clk);
      chk("R11", "done single cycle", int'(list_done), 0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      w = 0;
      while (!mc_ready && w < 50) begin @(negedge clk); w++; end
      chk("R8", "mc_ready for address within count", int'(mc_ready), 1);
      mc_valid = 1'b1;
      mc_addr  = base + 48'(i) * STEP;
      m_tbl[m_bin(mc_addr)] = 1'b1;
      @(negedge clk);
      mc_valid = 1'b0;
      c = 0;
      while (!mc_ready && !list_done && c < 20) begin c++; @(negedge clk); end
      if (i < n - 1) begin
        chk("R10", "clocks busy per address", c, 6);
      end else begin
        chk("R11", "clocks to done after last", c, 7);
        chk("R11", "list_done", int'(list_done), 1);
        @(negedge clk);
        chk("R11", "done single cycle", int'(list_done), 0);
        chk("R8", "mc_ready after count reached", int'(mc_ready), 0);
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] extra;
    logic        found;
    rst_n = 1'b0;
    cfg_promisc = 1'b0; cfg_bcast_off = 1'b0; cfg_mcast_en = 1'b1;
    cfg_min_len = 8'd0; station_addr = 48'h02123456789A;
    list_start = 1'b0; list_len = '0; mc_valid = 1'b0; mc_addr = '0;
    frm_valid = 1'b0; frm_dst = '0; frm_len = '0;
    exp_v = 1'b0; exp_acc = 1'b0; exp_grp = 1'b0; exp_req = "";
    m_tbl = '0;

    repeat (3) @(negedge clk);
    chk("R1", "dec_valid in reset", int'(dec_valid), 0);
    chk("R1", "dec_accept in reset", int'(dec_accept), 0);
    chk("R1", "mc_ready in reset", int'(mc_ready), 0);
    chk("R1", "list_done in reset", int'(list_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "mc_ready after reset", int'(mc_ready), 0);
    chk("R1", "dec_group after reset", int'(dec_group), 0);

    // empty table rejects multicast
    frame(48'h01005E0000AA, 64, "R1 empty table");
    frame(48'h01005E000000, 64, "R1 empty table");

    // unicast
    frame(48'h02123456789A, 64, "R7 match");
    frame(48'h02123456789B, 64, "R7 mismatch");
    frame(48'h00AABBCCDDEE, 64, "R7 mismatch");

    // broadcast
    frame(48'hFFFFFFFFFFFF, 64, "R5 enabled");
    cfg_bcast_off = 1'b1;
    frame(48'hFFFFFFFFFFFF, 64, "R5 disabled");
    cfg_bcast_off = 1'b0;

    // promiscuous
    cfg_promisc = 1'b1;
    frame(48'h00AABBCCDDEE, 64, "R4 unicast other");
    frame(48'h01005E123456, 64, "R4 multicast");
    frame(48'hFFFFFFFFFFFF, 64, "R4 broadcast");
    cfg_bcast_off = 1'b1;
    frame(48'hFFFFFFFFFFFF, 64, "R4 broadcast off");
    cfg_bcast_off = 1'b0;

    // length checks
    frame(48'h00AABBCCDDEE, 4, "R3 below floor");
    frame(48'h00AABBCCDDEE, 5, "R3 at floor");
    cfg_min_len = 8'd64;
    frame(48'h00AABBCCDDEE, 63, "R3 below min");
    frame(48'h00AABBCCDDEE, 64, "R3 at min");
    cfg_promisc = 1'b0;
    frame(48'h02123456789A, 63, "R3 unicast short");
    frame(48'hFFFFFFFFFFFF, 10, "R3 broadcast short");
    cfg_min_len = 8'd0;

    // two-address list (13 bytes)
    load_list(13, 48'h01005E000010);
    frame(48'h01005E000010, 64, "R6 R9 loaded 0");
    frame(48'h01005E000010 + STEP, 64, "R6 R9 loaded 1");
    frame(48'h01005E000010 + 48'd2 * STEP, 64, "R6 R8 not loaded");
    frame(48'h0300000000FF, 64, "R6 other group");
    cfg_mcast_en = 1'b0;
    frame(48'h01005E000010, 64, "R6 disabled");
    cfg_mcast_en = 1'b1;

    // reload clears earlier bins
    load_list(6, 48'h330000ABCDE1);
    frame(48'h01005E000010, 64, "R8 cleared");
    frame(48'h330000ABCDE1, 64, "R6 R9 reloaded");

    // empty list
    load_list(5, 48'h01005E000010);
    frame(48'h330000ABCDE1, 64, "R8 empty list");

    // capped list of 66 addresses
    load_list(400, 48'h01005E100000);
    for (int i = 0; i < 64; i += 9) begin
      frame(48'h01005E100000 + 48'(i) * STEP, 64, "R8 R9 capped list");
    end
    frame(48'h01005E100000 + 48'd64 * STEP, 64, "R8 beyond cap");
    frame(48'h01005E100000 + 48'd65 * STEP, 64, "R8 beyond cap");

    // mc_valid while not ready
    found = 1'b0;
    extra = '0;
    for (int j = 0; j < 400 && !found; j++) begin
      extra = 48'h0B0000000000 + 48'(j) * 48'h000000010001;
      if (!m_tbl[m_bin(extra)]) found = 1'b1;
    end
    @(negedge clk);
    mc_valid = 1'b1;
    mc_addr  = extra;
    repeat (4) @(negedge clk);
    chk("R11", "mc_ready while idle", int'(mc_ready), 0);
    mc_valid = 1'b0;
    frame(extra, 64, "R11 ignored address");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule